// File: doc/BRIEF.md
# General-Purpose Port Controller with Alternate Outputs

This block controls one port of eight pins. Software reaches it over a small register bus with a 3-bit address, an 8-bit write bus and one-cycle write and read strobes. Seven 8-bit registers, each holding one bit per pin, set the port up: output data, direction, open-drain, pull-select, pull-enable, and the low and high halves of a 2-bit output source code. From these registers the block drives, for each pin, an output value, an output enable and separate pull-up and pull-down requests to the pad. A read of the data address returns the pin levels.

Each pin's output comes from one of four sources. Code 0 selects the port data register. Codes 1, 2 and 3 select one of three peripheral outputs. The code is split across two registers: the high register gives the most significant bit of the code and the low register gives the least significant bit. Pin inputs pass through a two-flop synchronizer before any read sees them.

A parameter selects an input-only variant. That variant has no open-drain register and no source-select registers, and it never drives its pins.

Top module: `gpio_port`

## Requirements
- R1: After reset every register is zero. As a result all pins are inputs, pulls are off, open-drain is off, and every pin uses source code 0. `pad_oe_o`, `pad_pu_o` and `pad_pd_o` are all zero, and a read of any register returns 0.
- R2: A write stores `wdata_i` in the register at `addr_i`. A read strobe in cycle n captures the value of the addressed register in `rdata_o`, and the value is visible from cycle n+1 until the next read strobe. Address map: 0 data, 1 direction, 2 open-drain, 3 pull-select, 4 pull-enable, 5 source-code LSB, 6 source-code MSB.
- R3: In the full variant, pin p has source code {reg6[p], reg5[p]}. Code 0 drives the value of data[p], code 1 drives `alt1_i[p]`, code 2 drives `alt2_i[p]` and code 3 drives `alt3_i[p]`. When open-drain is off, `pad_out_o[p]` equals the selected source.
- R4: In the full variant, with open-drain off, `pad_oe_o[p]` equals direction bit p. A direction bit of 1 makes the pin an output and 0 makes it an input.
- R5: In the full variant, with open-drain bit p set, `pad_out_o[p]` is 0 and `pad_oe_o[p]` is direction[p] AND NOT source. A source value of 1 releases the pin and a value of 0 drives it low.
- R6: `pad_pu_o[p]` is pull-enable[p] AND pull-select[p]. `pad_pd_o[p]` is pull-enable[p] AND NOT pull-select[p]. A pull-select value of 1 means pull-up. The two are never both 1 on the same pin.
- R7: A read of address 0 returns, for each pin, the data register bit if its direction bit is 1, and otherwise the pin level sampled two clock edges earlier.
- R8: Address 7 reads as 0. A write to address 7 changes no register and no output.
- R9: In the input-only variant, `pad_oe_o` and `pad_out_o` are always 0 whatever the direction bits hold. Addresses 2, 5 and 6 read as 0 and ignore writes. A read of address 0 always returns the synchronized pin levels.
- R10: When a read and a write to the same address fall in the same cycle, the read returns the value the register held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| alt1_i | input | 8 | Peripheral output for source code 1, one bit per pin |
| alt2_i | input | 8 | Peripheral output for source code 2, one bit per pin |
| alt3_i | input | 8 | Peripheral output for source code 3, one bit per pin |
| pin_i | input | 8 | Pin levels from the pad, asynchronous |
| pad_out_o | output | 8 | Output value to the pad |
| pad_oe_o | output | 8 | Output enable to the pad |
| pad_pu_o | output | 8 | Pull-up request |
| pad_pd_o | output | 8 | Pull-down request |

## Verification
A read and a write can fall in the same cycle, on the same address or on different addresses. A write to the data or direction register can also land in the same cycle as a pin change that the synchronizer is still carrying. The bench provokes the same-address case directly: it strobes a read and a write of the direction register together and expects the old value, then reads again and expects the new one. A random phase then issues reads and writes at random addresses every cycle while the pins toggle. A behavioural model of both variants judges every cycle. In the model, the read value is taken before the write is applied, and two queued samples of the pin levels stand in for the synchronizer.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    parameter int PORT_W      = 8;
    parameter int ADDR_W      = 3;
    parameter int SYNC_STAGES = 2;
    parameter int ALT_SRCS    = 3;
    localparam int SEL_W      = $clog2(ALT_SRCS + 1);

    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_OD   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_PSEL = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_PEN  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_SLO  = 3'd5;
    localparam logic [ADDR_W-1:0] ADDR_SHI  = 3'd6;

    typedef struct packed {
        logic [PORT_W-1:0] data;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] od;
        logic [PORT_W-1:0] psel;
        logic [PORT_W-1:0] pen;
        logic [PORT_W-1:0] sel_lo;
        logic [PORT_W-1:0] sel_hi;
    } port_regs_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter bit HAS_ALT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PORT_W-1:0] wdata_i,
    input  logic [PORT_W-1:0] pin_sync_i,
    output port_regs_t        regs_o,
    output logic [PORT_W-1:0] rdata_o
);

    typedef struct packed {
        port_regs_t        regs;
        logic [PORT_W-1:0] rdata;
    } rf_state_t;

    rf_state_t         st_d, st_q;
    logic [PORT_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        unique case (addr_i)
            ADDR_DATA: rd_val = HAS_ALT ? ((st_q.regs.dir & st_q.regs.data) |
                                           (~st_q.regs.dir & pin_sync_i))
                                        : pin_sync_i;
            ADDR_DIR:  rd_val = st_q.regs.dir;
            ADDR_OD:   rd_val = HAS_ALT ? st_q.regs.od : '0;
            ADDR_PSEL: rd_val = st_q.regs.psel;
            ADDR_PEN:  rd_val = st_q.regs.pen;
            ADDR_SLO:  rd_val = HAS_ALT ? st_q.regs.sel_lo : '0;
            ADDR_SHI:  rd_val = HAS_ALT ? st_q.regs.sel_hi : '0;
            default:   rd_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_en_i) st_d.rdata = rd_val;
        if (wr_en_i) begin
            unique case (addr_i)
                ADDR_DATA: st_d.regs.data = wdata_i;
                ADDR_DIR:  st_d.regs.dir  = wdata_i;
                ADDR_OD:   if (HAS_ALT) st_d.regs.od = wdata_i;
                ADDR_PSEL: st_d.regs.psel = wdata_i;
                ADDR_PEN:  st_d.regs.pen  = wdata_i;
                ADDR_SLO:  if (HAS_ALT) st_d.regs.sel_lo = wdata_i;
                ADDR_SHI:  if (HAS_ALT) st_d.regs.sel_hi = wdata_i;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o  = st_q.regs;
    assign rdata_o = st_q.rdata;

    // R2
    dir_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_DIR) |=> (regs_o.dir == $past(wdata_i)));

    // R10
    rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && wr_en_i && addr_i == ADDR_DIR) |=> (rdata_o == $past(regs_o.dir)));

    // R8
    hole_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd7) |=> $stable(regs_o));

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_pkg::*;
#(
    parameter bit HAS_ALT = 1'b1
) (
    input  logic                data_i,
    input  logic                dir_i,
    input  logic                od_i,
    input  logic                psel_i,
    input  logic                pen_i,
    input  logic [SEL_W-1:0]    code_i,
    input  logic [ALT_SRCS-1:0] alt_i,
    output logic                out_o,
    output logic                oe_o,
    output logic                pu_o,
    output logic                pd_o
);

    logic [ALT_SRCS:0] srcs;
    logic              src;

    assign srcs = {alt_i, data_i};

    generate
        if (HAS_ALT) begin : g_bidir
            always_comb begin
                src = srcs[code_i];
                if (od_i) begin
                    out_o = 1'b0;
                    oe_o  = dir_i & ~src;
                end else begin
                    out_o = src;
                    oe_o  = dir_i;
                end
            end
        end else begin : g_inonly
            always_comb begin
                src   = 1'b0;
                out_o = 1'b0;
                oe_o  = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        pu_o = pen_i & psel_i;
        pd_o = pen_i & ~psel_i;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter bit HAS_ALT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PORT_W-1:0] wdata_i,
    output logic [PORT_W-1:0] rdata_o,
    input  logic [PORT_W-1:0] alt1_i,
    input  logic [PORT_W-1:0] alt2_i,
    input  logic [PORT_W-1:0] alt3_i,
    input  logic [PORT_W-1:0] pin_i,
    output logic [PORT_W-1:0] pad_out_o,
    output logic [PORT_W-1:0] pad_oe_o,
    output logic [PORT_W-1:0] pad_pu_o,
    output logic [PORT_W-1:0] pad_pd_o
);

    port_regs_t        regs;
    logic [PORT_W-1:0] pin_sync;

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    gpio_regfile #(.HAS_ALT(HAS_ALT)) i_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .pin_sync_i (pin_sync),
        .regs_o     (regs),
        .rdata_o    (rdata_o)
    );

    generate
        for (genvar p = 0; p < PORT_W; p++) begin : g_pin
            gpio_pin_cell #(.HAS_ALT(HAS_ALT)) i_cell (
                .data_i (regs.data[p]),
                .dir_i  (regs.dir[p]),
                .od_i   (regs.od[p]),
                .psel_i (regs.psel[p]),
                .pen_i  (regs.pen[p]),
                .code_i ({regs.sel_hi[p], regs.sel_lo[p]}),
                .alt_i  ({alt3_i[p], alt2_i[p], alt1_i[p]}),
                .out_o  (pad_out_o[p]),
                .oe_o   (pad_oe_o[p]),
                .pu_o   (pad_pu_o[p]),
                .pd_o   (pad_pd_o[p])
            );
        end
    endgenerate

    // R6
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu_o & pad_pd_o) == '0));

    // R5
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((regs.od & pad_out_o) == '0));

    generate
        if (!HAS_ALT) begin : g_inonly_chk
            // R9
            inonly_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pad_oe_o == '0 && pad_out_o == '0));
        end
    endgenerate

endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, alt1 = '0, alt2 = '0, alt3 = '0, pin = '0;
    logic [7:0] rd_f, out_f, oe_f, pu_f, pd_f;
    logic [7:0] rd_i, out_i, oe_i, pu_i, pd_i;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port #(.HAS_ALT(1'b1)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_f),
        .alt1_i(alt1), .alt2_i(alt2), .alt3_i(alt3), .pin_i(pin),
        .pad_out_o(out_f), .pad_oe_o(oe_f), .pad_pu_o(pu_f), .pad_pd_o(pd_f)
    );

    gpio_port #(.HAS_ALT(1'b0)) i_gpio_port_in (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rd_i),
        .alt1_i(alt1), .alt2_i(alt2), .alt3_i(alt3), .pin_i(pin),
        .pad_out_o(out_i), .pad_oe_o(oe_i), .pad_pu_o(pu_i), .pad_pd_o(pd_i)
    );

    // Behavioural model: register arrays by address, pin sample queue
    logic [7:0] mf [8];
    logic [7:0] mi [8];
    logic [7:0] pin_q [$];
    logic [7:0] mrd_f = '0, mrd_i = '0;

    initial begin
        for (int a = 0; a < 8; a++) begin mf[a] = '0; mi[a] = '0; end
        pin_q = '{8'h00, 8'h00};
    end

    function automatic logic [7:0] model_read(bit full, logic [2:0] a, logic [7:0] synced);
        if (a == 3'd7) return 8'h00;
        if (full) begin
            if (a == 3'd0) return (mf[1] & mf[0]) | (~mf[1] & synced);
            return mf[a];
        end
        if (a == 3'd0) return synced;
        if (a == 3'd2 || a == 3'd5 || a == 3'd6) return 8'h00;
        return mi[a];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 8; a++) begin mf[a] = '0; mi[a] = '0; end
            pin_q = '{8'h00, 8'h00};
            mrd_f = '0; mrd_i = '0;
        end else begin
            if (rd_en) begin
                mrd_f = model_read(1'b1, addr, pin_q[0]);
                mrd_i = model_read(1'b0, addr, pin_q[0]);
            end
            if (wr_en && addr != 3'd7) begin
                mf[addr] = wdata;
                if (!(addr == 3'd2 || addr == 3'd5 || addr == 3'd6)) mi[addr] = wdata;
            end
            void'(pin_q.pop_front());
            pin_q.push_back(pin);
        end
    end

    function automatic logic [7:0] exp_out(bit want_oe);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            int code;
            logic src;
            code = 2 * int'(mf[6][b]) + int'(mf[5][b]);
            case (code)
                0: src = mf[0][b];
                1: src = alt1[b];
                2: src = alt2[b];
                default: src = alt3[b];
            endcase
            if (want_oe) r[b] = mf[1][b] & (mf[2][b] ? ~src : 1'b1);
            else         r[b] = mf[2][b] ? 1'b0 : src;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 full pad_out", out_f, exp_out(1'b0));
            check("R4/R5 full pad_oe", oe_f, exp_out(1'b1));
            check("R6 full pull-up", pu_f, mf[4] & mf[3]);
            check("R6 full pull-down", pd_f, mf[4] & ~mf[3]);
            check("R2/R7 full rdata", rd_f, mrd_f);
            check("R9 inonly pad_out", out_i, 8'h00);
            check("R9 inonly pad_oe", oe_i, 8'h00);
            check("R6 inonly pull-up", pu_i, mi[4] & mi[3]);
            check("R6 inonly pull-down", pd_i, mi[4] & ~mi[3]);
            check("R7/R9 inonly rdata", rd_i, mrd_i);
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe after reset", oe_f, 8'h00);
        check("R1 pull-up after reset", pu_f, 8'h00);
        check("R1 pull-down after reset", pd_f, 8'h00);
        rd(3'd6);
        check("R1 select MSB reads zero", rd_f, 8'h00);
        // R2 write and read back
        wr(3'd3, 8'hA5);
        rd(3'd3);
        check("R2 pull-select readback", rd_f, 8'hA5);
        // R3 source selection
        alt1 = 8'hFF; alt2 = 8'h00; alt3 = 8'h00;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'hFF);
        wr(3'd5, 8'hAA);
        wr(3'd6, 8'hCC);
        @(negedge clk);
        check("R3 code1 pins follow alt1", out_f, 8'h22);
        check("R4 all outputs enabled", oe_f, 8'hFF);
        alt1 = 8'h00; alt3 = 8'hFF;
        @(negedge clk);
        check("R3 code3 pins follow alt3", out_f, 8'h88);
        // R5 open-drain
        wr(3'd2, 8'hFF);
        @(negedge clk);
        check("R5 open-drain out low", out_f, 8'h00);
        check("R5 open-drain oe", oe_f, 8'h77);
        // R9 input-only ignores od and direction
        check("R9 inonly oe with dir set", oe_i, 8'h00);
        rd(3'd2);
        check("R9 inonly od reads zero", rd_i, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h00);
        // R7 data read mixes pins and data
        wr(3'd1, 8'h0F);
        pin = 8'hF0;
        repeat (3) @(negedge clk);
        rd(3'd0);
        check("R7 mixed data read", rd_f, 8'hF0);
        check("R9 inonly data read", rd_i, 8'hF0);
        // R8 unused address
        wr(3'd7, 8'hFF);
        rd(3'd7);
        check("R8 address 7 reads zero", rd_f, 8'h00);
        check("R8 outputs unchanged", oe_f, 8'h0F);
        // R10 same-cycle read and write
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 3'd1; wdata = 8'h5A;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R10 read returns old value", rd_f, 8'h0F);
        rd(3'd1);
        check("R10 second read returns new value", rd_f, 8'h5A);
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            wr_en = 1'($urandom);
            rd_en = 1'($urandom);
            addr  = 3'($urandom);
            wdata = 8'($urandom);
            pin   = 8'($urandom);
            alt1  = 8'($urandom);
            alt2  = 8'($urandom);
            alt3  = 8'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule